// File: doc/BRIEF.md
# Gated-Clock Parallel-to-Serial Shifter

This block turns a parallel word into a serial bit stream. A word presented on the direct data inputs is captured while the active-low load control is held low. After load is released, each effective clock moves every bit one stage toward the last stage, and the serial input fills the first stage. The last stage is driven out both as a true output and as an inverted output. Several blocks can be chained by feeding one block's true output into the next block's serial input.

Two external clock pins share the clock role. The effective shift event is a rising edge of their logical OR, so holding either pin high blocks shifting and the other pin then does nothing. Either pin can serve as the clock while the other is held low as an inhibit. The inhibit pin must only be raised while the active clock pin is high, so that raising it never makes a new edge.

The block runs on a free-running system clock. The two clock pins and the load pin pass through multi-flop synchronizers, and edges are found from the synchronized samples. The system clock must run at least four times faster than the external shift clock. Load overrides shifting: while the synchronized load level is low, the register follows the parallel inputs on every system clock and ignores external clock edges.

Top module: `piso_gated_shifter`

## Requirements
- R1: While reset is asserted, all stages clear: the true output is 0 and the inverted output is 1.
- R2: While the load pin is low, the register follows the parallel inputs on every system clock, with parallel bit WIDTH-1 in the last stage, so the true output shows par_in[WIDTH-1] within SYNC_STAGES+2 system clocks.
- R3: While the load pin is low, external clock edges, the inhibit level and the serial input cause no shift.
- R4: With the load pin high, a rising edge of (ext_clk_a OR ext_clk_b) shifts every stage one position toward the last stage and puts ser_in into the first stage.
- R5: While either clock pin is held high, toggling the other causes no shift.
- R6: Raising one clock pin while the other is already high causes no shift, and either pin can be the active clock.
- R7: After loading value D, successive shifts present D[WIDTH-1], D[WIDTH-2], ... D[0] on the true output, followed by the serial input bits in the order they were shifted in; chained blocks form one longer register.
- R8: The inverted output is always the complement of the true output.
- R9: A load applied in the same cycle as a clock edge, part way through shifting out a word, wins: the shift is abandoned and the new parallel word is in the register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk_a | input | 1 | External clock pin A (clock or inhibit) |
| ext_clk_b | input | 1 | External clock pin B (clock or inhibit) |
| ld_n | input | 1 | Active-low load control, asynchronous pin |
| ser_in | input | 1 | Serial data into the first stage |
| par_in | input | WIDTH | Direct parallel data, bit WIDTH-1 goes to the last stage |
| q_last | output | 1 | True value of the last stage |
| q_last_n | output | 1 | Inverted value of the last stage |

## Verification
The bench raises the inhibit pin while the active clock is high and checks that no bit moves; a design that treated each pin's edge separately, instead of the OR, would shift an extra place and every later bit would arrive early. It toggles clocks and the serial input while load is low and changes the parallel word mid-load, which catches a design that shifts during load or captures only on the load edge. It applies a load on the very cycle of a clock edge part way through a word, where a design giving shift priority would emit a mixture of old and new bits. A two-block chain checks that both blocks sample on the same event, since a skewed design would duplicate or drop the bit crossing between them.

// File: rtl/piso_pkg.sv
package piso_pkg;
   // positions of the asynchronous pins in the synchronizer vector
   localparam int unsigned PIN_CLK_A = 0;
   localparam int unsigned PIN_CLK_B = 1;
   localparam int unsigned PIN_LOAD  = 2;
   localparam int unsigned PIN_COUNT = 3;
   // reset level of the synchronized pins: clocks high (no edge at release), load idle
   localparam logic [PIN_COUNT-1:0] PIN_RESET = 3'b111;
endpackage

// File: rtl/piso_sync.sv
module piso_sync #(
   parameter int unsigned    WIDTH   = 1,
   parameter int unsigned    STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0][WIDTH-1:0] ff;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < STAGES; s++) ff[s] <= RST_VAL;
            end else begin
               ff[0] <= d;
               for (int s = 1; s < STAGES; s++) ff[s] <= ff[s-1];
            end
         end
         assign q = ff[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/piso_clk_event.sv
module piso_clk_event (
   input  logic clk,
   input  logic rst_n,
   input  logic clk_a_s,
   input  logic clk_b_s,
   input  logic ld_n_s,
   output logic shift_evt
);
   logic gated;
   logic gated_prev;

   // either pin held high keeps the combined clock high: that is the inhibit
   assign gated = clk_a_s | clk_b_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gated_prev <= 1'b1;
      else        gated_prev <= gated;
   end

   assign shift_evt = gated & ~gated_prev & ld_n_s;
endmodule

// File: rtl/piso_stage_chain.sv
module piso_stage_chain #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_en,
   input  logic             shift_en,
   input  logic [WIDTH-1:0] par_in,
   input  logic             ser_in,
   output logic [WIDTH-1:0] stage_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        stage_q <= '0;
      else if (load_en)  stage_q <= par_in;
      else if (shift_en) stage_q <= {stage_q[WIDTH-2:0], ser_in};
   end
endmodule

// File: rtl/piso_gated_shifter.sv
module piso_gated_shifter #(
   parameter int unsigned WIDTH       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_clk_a,
   input  logic             ext_clk_b,
   input  logic             ld_n,
   input  logic             ser_in,
   input  logic [WIDTH-1:0] par_in,
   output logic             q_last,
   output logic             q_last_n
);
   import piso_pkg::*;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("piso_gated_shifter: WIDTH must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("piso_gated_shifter: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [PIN_COUNT-1:0] pins_raw;
   logic [PIN_COUNT-1:0] pins_s;
   logic                 ld_sync;
   logic                 shift_evt;
   logic [WIDTH-1:0]     stage_q;

   assign pins_raw[PIN_CLK_A] = ext_clk_a;
   assign pins_raw[PIN_CLK_B] = ext_clk_b;
   assign pins_raw[PIN_LOAD]  = ld_n;

   piso_sync #(
      .WIDTH   (PIN_COUNT),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (PIN_RESET)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pins_raw),
      .q     (pins_s)
   );

   assign ld_sync = pins_s[PIN_LOAD];

   piso_clk_event u_event (
      .clk       (clk),
      .rst_n     (rst_n),
      .clk_a_s   (pins_s[PIN_CLK_A]),
      .clk_b_s   (pins_s[PIN_CLK_B]),
      .ld_n_s    (ld_sync),
      .shift_evt (shift_evt)
   );

   piso_stage_chain #(
      .WIDTH (WIDTH)
   ) u_chain (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_en  (~ld_sync),
      .shift_en (shift_evt),
      .par_in   (par_in),
      .ser_in   (ser_in),
      .stage_q  (stage_q)
   );

   assign q_last   = stage_q[WIDTH-1];
   assign q_last_n = ~stage_q[WIDTH-1];
endmodule

// File: rtl/piso_gated_shifter_chk.sv
module piso_gated_shifter_chk #(
   parameter int unsigned WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ld_sync,
   input logic             shift_evt,
   input logic [WIDTH-1:0] stage_q,
   input logic [WIDTH-1:0] par_in,
   input logic             ser_in,
   input logic             q_last
);
   assert_load_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_sync |=> stage_q == $past(par_in));

   assert_shift_move_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_sync && shift_evt) |=> stage_q == {$past(stage_q[WIDTH-2:0]), $past(ser_in)});

   assert_no_event_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_sync && !shift_evt) |=> $stable(stage_q));

   assert_out_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_sync && shift_evt) |=> q_last == $past(stage_q[WIDTH-2]));
endmodule

bind piso_gated_shifter piso_gated_shifter_chk #(.WIDTH(WIDTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ld_sync   (ld_sync),
   .shift_evt (shift_evt),
   .stage_q   (stage_q),
   .par_in    (par_in),
   .ser_in    (ser_in),
   .q_last    (q_last)
);

// File: tb/piso_gated_shifter_tb_top.sv
module piso_gated_shifter_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int SETTLE     = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pin_a = 1'b0;
   logic       pin_b = 1'b0;
   logic       pin_ld = 1'b1;
   logic       ser = 1'b0;
   logic [7:0] par1 = 8'h00;
   logic [7:0] par2 = 8'h00;
   logic       q1, q1_n, q2, q2_n;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   piso_gated_shifter dut_i (
      .clk(clk), .rst_n(rst_n), .ext_clk_a(pin_a), .ext_clk_b(pin_b),
      .ld_n(pin_ld), .ser_in(ser), .par_in(par1), .q_last(q1), .q_last_n(q1_n));

   // second block chained behind the first
   piso_gated_shifter dut2_i (
      .clk(clk), .rst_n(rst_n), .ext_clk_a(pin_a), .ext_clk_b(pin_b),
      .ld_n(pin_ld), .ser_in(q1), .par_in(par2), .q_last(q2), .q_last_n(q2_n));

   // {use pin B as clock, load word, serial word, expected 16-bit output stream}
   localparam logic [32:0] VEC [4] = '{
      {1'b0, 8'h96, 8'h3A, 16'h963A},
      {1'b1, 8'h01, 8'hFF, 16'h01FF},
      {1'b0, 8'hFF, 8'h00, 16'hFF00},
      {1'b1, 8'h4D, 8'hB2, 16'h4DB2}
   };

   task automatic wait_sys(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
      end
   endtask

   // true output against expectation, and R8 complement on every observation
   task automatic chk_out(input string req, input logic exp);
      chk(req, q1, exp);
      chk("R8", q1_n, ~q1);
   endtask

   task automatic pulse(input bit use_b);
      if (use_b) pin_b = 1'b1; else pin_a = 1'b1;
      wait_sys(SETTLE);
      if (use_b) pin_b = 1'b0; else pin_a = 1'b0;
      wait_sys(SETTLE);
   endtask

   task automatic load_word(input logic [7:0] w1, input logic [7:0] w2);
      par1 = w1; par2 = w2; pin_ld = 1'b0;
      wait_sys(SETTLE);
      pin_ld = 1'b1;
      wait_sys(SETTLE);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      // R1: reset state
      wait_sys(3);
      chk("R1", q1, 1'b0);
      chk("R1", q1_n, 1'b1);
      rst_n = 1'b1;
      wait_sys(SETTLE);
      chk_out("R1", 1'b0);

      // table walk: R4, R7 with either pin as clock
      for (int v = 0; v < 4; v++) begin
         logic        use_b;
         logic [7:0]  d, s;
         logic [15:0] e;
         {use_b, d, s, e} = VEC[v];
         load_word(d, 8'h00);
         chk_out("R7", e[15]);
         for (int k = 1; k < 16; k++) begin
            ser = (k <= 8) ? s[8-k] : 1'b0;
            wait_sys(1);
            pulse(use_b);
            chk_out("R4", e[15-k]);
         end
      end

      // R2, R3: load held low; clocks and serial input ignored, word followed
      par1 = 8'hA5; pin_ld = 1'b0; ser = 1'b1;
      wait_sys(SETTLE);
      for (int k = 0; k < 3; k++) pulse(1'b0);
      pulse(1'b1);
      chk_out("R3", 1'b1);
      par1 = 8'h3C;
      wait_sys(SETTLE);
      chk_out("R2", 1'b0);
      pin_ld = 1'b1; ser = 1'b0;
      wait_sys(SETTLE);
      for (int k = 0; k < 8; k++) begin
         chk_out("R2", par1[7-k]);
         pulse(1'b0);
      end

      // R5: inhibit pin B held high, pin A toggles without effect
      par1 = 8'hB4; pin_ld = 1'b0;
      wait_sys(SETTLE);
      pin_b = 1'b1;
      wait_sys(SETTLE);
      pin_ld = 1'b1;
      wait_sys(SETTLE);
      for (int k = 0; k < 5; k++) pulse(1'b0);
      chk_out("R5", 1'b1);
      pin_b = 1'b0;
      wait_sys(SETTLE);
      chk_out("R5", 1'b1);
      pulse(1'b0);
      chk_out("R5", 1'b0);

      // R6: raise inhibit while clock high, then swap clock roles
      load_word(8'h5A, 8'h00);
      pin_a = 1'b1;
      wait_sys(SETTLE);
      chk_out("R6", 1'b1);
      pin_b = 1'b1;
      wait_sys(SETTLE);
      chk_out("R6", 1'b1);
      pin_a = 1'b0;
      wait_sys(SETTLE);
      chk_out("R6", 1'b1);
      pin_b = 1'b0;
      wait_sys(SETTLE);
      pin_b = 1'b1;
      wait_sys(SETTLE);
      chk_out("R6", 1'b0);
      pin_b = 1'b0;
      wait_sys(SETTLE);

      // R9: load on the same cycle as a clock edge, mid-word
      load_word(8'hF0, 8'h00);
      for (int k = 0; k < 3; k++) pulse(1'b0);
      chk_out("R9", 1'b1);
      par1 = 8'h0F;
      pin_ld = 1'b0; pin_a = 1'b1;
      wait_sys(SETTLE);
      chk_out("R9", 1'b0);
      pin_a = 1'b0;
      wait_sys(SETTLE);
      pin_ld = 1'b1;
      wait_sys(SETTLE);
      for (int k = 0; k < 8; k++) begin
         chk_out("R9", par1[7-k]);
         pulse(1'b0);
      end

      // R7: two chained blocks act as one 16-bit register
      ser = 1'b0;
      load_word(8'h69, 8'hC3);
      for (int k = 0; k < 16; k++) begin
         logic [15:0] chain_word;
         chain_word = 16'hC369;
         chk("R7", q2, chain_word[15-k]);
         chk("R8", q2_n, ~q2);
         pulse(1'b1);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule